// File: doc/BRIEF.md
# Masked Latched Interrupt Status Registers

This block collects seven single-cycle event pulses from a serial link controller's packet engine and turns them into software-visible interrupt state. Each pulse sets a sticky bit in a latched-event register. An enable register selects which of those latched events may raise an interrupt. A third, read-only view reports the latched events that are enabled. A single registered interrupt line is high while any enabled latched event is pending.

Software reaches the block through a small word-wide port with a read strobe, a write strobe and a two-bit address. Reads clear state as a side effect, and both read paths clear latched events. A read of the latched-event register empties it completely. A read of the enabled-event view clears only the events it reported, so disabled events stay latched for later inspection. The data returned by a read always shows the state before the clear. An event that arrives in the same cycle as a clearing read survives the clear.

There is no state machine. The block is three register banks and one combinational read multiplexer.

Top module: `irq_status_regs`

## Requirements
- R1: After a cycle with `rst_i` high, every latched bit and every enable bit is 0 and `irq_o` is 0. Reads at addresses 0, 1 and 2 then return 0x0000.
- R2: A pulse on `event_i[k]` sets the latched bit at word position 2+k, and the bit stays set until it is cleared. The event map is: k=0 transmit FIFO empty (bit 2), k=1 frame abort (bit 3), k=2 transmit FIFO low (bit 4), k=3 end of packet read (bit 5), k=4 transmit end of packet (bit 6), k=5 end of packet detected (bit 7), k=6 go-ahead (bit 8).
- R3: A read at address 2 (enabled-event view) returns the bitwise AND of the latched bits and the enable bits, at positions 8..2. Bits 15..9 and 1..0 read 0 at every address.
- R4: A read at address 0 returns the latched bits as they were before the read. It clears all latched bits on the clock edge that ends the read cycle.
- R5: A read at address 2 returns the enabled latched bits as they were before the read. It clears only those bits on the clock edge that ends the read cycle, and latched bits whose enable is 0 stay set.
- R6: If an event pulse arrives in the same cycle as a clearing read, the event's latched bit is set after that clock edge.
- R7: A write at address 1 loads `wdata_i[8:2]` into the enable register, where 1 enables. A read at address 1 returns the enable bits and clears nothing. Writes at addresses 0, 2 and 3 change no state.
- R8: `irq_o` is a register. In each cycle it equals the OR of (latched AND enable) as it stood in the previous cycle.
- R9: A read at address 3 returns 0x0000 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| event_i | input | 7 | Single-cycle event pulses, bit k maps to word bit 2+k |
| rd_i | input | 1 | Read strobe, one cycle per read |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address: 0 latched, 1 enable, 2 enabled view, 3 unused |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the cycle `rd_i` is high |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
A latched bit that is lost, or that clears when it should not, shows up at the very next read of address 0. It also shows at the next read of address 2 when the bit is enabled. A fault in the enable register, such as a bad write decode, shows the same way through reads of address 1 and address 2. Any fault in the enabled-event view also appears on `irq_o` one cycle after it arises, because that output is registered. Wrong clear scoping is caught in two ways. A masked bit that vanishes after a read of address 2 shows on the following read of address 0. An event lost to a simultaneous clear shows on the next read of address 0.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int NUM_EV = 7;
    localparam int EV_LSB = 2;

    localparam logic [ADDR_W-1:0] ADDR_LATCH = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_VIEW = 2'd2;

    typedef enum logic [1:0] {
        SEL_LATCH = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_VIEW = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int N = 7
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] lat_o
);

    logic [N-1:0] lat_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                lat_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                lat_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
                lat_q[i] <= 1'b0;
            end
        end

        assert_event_sets_R2: assert property (@(posedge clk_i) disable iff (rst_i)
            set_i[i] |=> lat_q[i]);
        assert_sticky_R2: assert property (@(posedge clk_i) disable iff (rst_i)
            (lat_q[i] && !clr_i[i]) |=> lat_q[i]);
        assert_set_beats_clear_R6: assert property (@(posedge clk_i) disable iff (rst_i)
            (set_i[i] && clr_i[i]) |=> lat_q[i]);
    end

    assign lat_o = lat_q;

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int N = 7
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         we_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] en_o
);

    logic [N-1:0] en_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q <= '0;
        end else if (we_i) begin
            en_q <= wdata_i;
        end
    end

    assign en_o = en_q;

    assert_enable_holds_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !we_i |=> $stable(en_q));
    assert_enable_loads_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |=> (en_q == $past(wdata_i)));

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_regs_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_NUM_EV = NUM_EV,
    parameter int P_EV_LSB = EV_LSB
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [P_NUM_EV-1:0] event_i,
    input  logic                rd_i,
    input  logic                wr_i,
    input  logic [P_ADDR_W-1:0] addr_i,
    input  logic [P_DATA_W-1:0] wdata_i,
    output logic [P_DATA_W-1:0] rdata_o,
    output logic                irq_o
);

    localparam int FIELD_MSB = P_EV_LSB + P_NUM_EV - 1;
    localparam logic [P_DATA_W-1:0] FIELD_MASK =
        {{(P_DATA_W-P_NUM_EV){1'b0}}, {P_NUM_EV{1'b1}}} << P_EV_LSB;

    reg_sel_e            sel;
    logic [P_NUM_EV-1:0] lat;
    logic [P_NUM_EV-1:0] en;
    logic [P_NUM_EV-1:0] view;
    logic [P_NUM_EV-1:0] clr;
    logic [P_NUM_EV-1:0] field;
    logic                en_we;
    logic                irq_q;

    always_comb begin
        unique case (addr_i)
            ADDR_LATCH:  sel = SEL_LATCH;
            ADDR_ENABLE: sel = SEL_ENABLE;
            ADDR_VIEW:   sel = SEL_VIEW;
            default:     sel = SEL_NONE;
        endcase
    end

    assign view  = lat & en;
    assign en_we = wr_i && (sel == SEL_ENABLE);

    always_comb begin
        clr = '0;
        if (rd_i) begin
            unique case (sel)
                SEL_LATCH: clr = '1;
                SEL_VIEW:  clr = view;
                default:   clr = '0;
            endcase
        end
    end

    irq_latch_bank #(.N(P_NUM_EV)) u_latch (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .set_i (event_i),
        .clr_i (clr),
        .lat_o (lat)
    );

    irq_enable_reg #(.N(P_NUM_EV)) u_enable (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (en_we),
        .wdata_i (wdata_i[FIELD_MSB:P_EV_LSB]),
        .en_o    (en)
    );

    always_comb begin
        unique case (sel)
            SEL_LATCH:  field = lat;
            SEL_ENABLE: field = en;
            SEL_VIEW:   field = view;
            default:    field = '0;
        endcase
        rdata_o = '0;
        rdata_o[FIELD_MSB:P_EV_LSB] = field;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |view;
        end
    end

    assign irq_o = irq_q;

    assert_unused_zero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (rdata_o & ~FIELD_MASK) == '0);
    assert_irq_rise_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (|(lat & en)) |=> irq_o);
    assert_irq_fall_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !(|(lat & en)) |=> !irq_o);
    assert_latch_read_empties_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && addr_i == ADDR_LATCH && event_i == '0) |=> (lat == '0));
    assert_view_read_keeps_masked_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && addr_i == ADDR_VIEW) |=> ((lat & ~en) == ($past(lat) & ~$past(en))) || (|$past(event_i)));
    assert_spare_addr_inert_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (addr_i == 2'd3) |-> (clr == '0 && rdata_o == '0));

endmodule

// File: tb/irq_status_regs_tb.sv
module irq_status_regs_tb;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [6:0]  event_i = '0;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [1:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        irq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk_i = ~clk_i;

    irq_status_regs u_dut (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .event_i (event_i),
        .rd_i    (rd_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    // Vector: {req[3:0], ev[6:0], rd, wr, addr[1:0], wdata[15:0], exp_rdata[15:0], exp_irq}
    localparam int NV = 24;
    localparam logic [47:0] VEC [NV] = '{
        {4'd1, 7'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0}, // R1 empty latch
        {4'd2, 7'h40, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0}, // R2 go-ahead
        {4'd3, 7'h00, 1'b1, 1'b0, 2'd2, 16'h0000, 16'h0000, 1'b0}, // R3 all disabled
        {4'd2, 7'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0100, 1'b0}, // R2 bit 8 sticky
        {4'd7, 7'h00, 1'b0, 1'b1, 2'd1, 16'hFFFF, 16'h0000, 1'b0}, // R7 enable all
        {4'd7, 7'h00, 1'b1, 1'b0, 2'd1, 16'h0000, 16'h01FC, 1'b0}, // R7 readback
        {4'd2, 7'h09, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0}, // R2 bits 2,5
        {4'd8, 7'h00, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0}, // R8 still low
        {4'd5, 7'h00, 1'b1, 1'b0, 2'd2, 16'h0000, 16'h0024, 1'b1}, // R5 view read
        {4'd5, 7'h00, 1'b1, 1'b0, 2'd2, 16'h0000, 16'h0000, 1'b1}, // R5 cleared, R8 lag
        {4'd7, 7'h00, 1'b0, 1'b1, 2'd1, 16'h0010, 16'h0000, 1'b0}, // R7 enable bit 4
        {4'd2, 7'h05, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0}, // R2 bits 2,4
        {4'd5, 7'h00, 1'b1, 1'b0, 2'd2, 16'h0000, 16'h0010, 1'b0}, // R5 view shows bit 4
        {4'd5, 7'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0004, 1'b1}, // R5 masked bit kept
        {4'd6, 7'h02, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0}, // R6 set during clear
        {4'd6, 7'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0008, 1'b0}, // R6 bit 3 survived
        {4'd7, 7'h00, 1'b0, 1'b1, 2'd0, 16'hFFFF, 16'h0000, 1'b0}, // R7 write addr 0
        {4'd7, 7'h00, 1'b0, 1'b1, 2'd2, 16'hFFFF, 16'h0000, 1'b0}, // R7 write addr 2
        {4'd7, 7'h00, 1'b1, 1'b0, 2'd1, 16'h0000, 16'h0010, 1'b0}, // R7 enable unchanged
        {4'd2, 7'h7F, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0}, // R2 all events
        {4'd9, 7'h00, 1'b1, 1'b0, 2'd3, 16'h0000, 16'h0000, 1'b0}, // R9 spare read
        {4'd4, 7'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h01FC, 1'b1}, // R4 full map, R9 no clear
        {4'd8, 7'h00, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b1}, // R8 one-cycle lag
        {4'd4, 7'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0}  // R4 emptied
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [6:0] ev, input logic rd, input logic wr,
                        input logic [1:0] addr, input logic [15:0] wd);
        @(negedge clk_i);
        event_i = ev;
        rd_i = rd;
        wr_i = wr;
        addr_i = addr;
        wdata_i = wd;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_i = 1'b0;
        // R1 reset state
        step(7'h00, 1'b1, 1'b0, 2'd1, 16'h0000);
        check("R1 enable", rdata_o, 16'h0000);
        check("R1 irq", {15'd0, irq_o}, 16'h0000);
        step(7'h00, 1'b1, 1'b0, 2'd2, 16'h0000);
        check("R1 view", rdata_o, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            v = VEC[i];
            step(v[43:37], v[36], v[35], v[34:33], v[32:17]);
            if (v[36]) check($sformatf("R%0d vec %0d rdata", v[47:44], i), rdata_o, v[16:1]);
            check($sformatf("R%0d vec %0d irq", v[47:44], i), {15'd0, irq_o}, {15'd0, v[0]});
        end

        // R1: reset mid-operation clears latched, enable, irq
        step(7'h7F, 1'b0, 1'b1, 2'd1, 16'hFFFF);
        step(7'h00, 1'b0, 1'b0, 2'd0, 16'h0000);
        step(7'h00, 1'b0, 1'b0, 2'd0, 16'h0000);
        check("R8 irq high before reset", {15'd0, irq_o}, 16'h0001);
        @(negedge clk_i);
        rst_i = 1'b1;
        @(negedge clk_i);
        rst_i = 1'b0;
        step(7'h00, 1'b0, 1'b0, 2'd0, 16'h0000);
        check("R1 irq after reset", {15'd0, irq_o}, 16'h0000);
        step(7'h00, 1'b1, 1'b0, 2'd1, 16'h0000);
        check("R1 enable after reset", rdata_o, 16'h0000);
        step(7'h00, 1'b1, 1'b0, 2'd0, 16'h0000);
        check("R1 latch after reset", rdata_o, 16'h0000);

        // R3: unused bits stay zero with everything set
        step(7'h7F, 1'b0, 1'b1, 2'd1, 16'hFFFF);
        step(7'h00, 1'b1, 1'b0, 2'd2, 16'h0000);
        check("R3 view upper/lower zero", rdata_o, 16'h01FC);
        step(7'h00, 1'b0, 1'b0, 2'd0, 16'h0000);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk_i);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule